// File: doc/BRIEF.md
# Quarter-phase serial frame transmitter

This block turns a 17-bit parallel word into a serial frame on two wires, a data line and a clock line. Every bit period is split into four equal quarters. The data line carries two values in each bit period. In the first half it carries the payload bit. In the second half it carries a latch flag, which tells the receiver when to store the word it has collected. The clock line is high only during the middle two quarters. As a result, each data change comes one quarter before the clock edge that follows it, and the line is stable at both the rising and the falling clock edge.

A frame begins with a one-cycle start pulse while the block is idle. On that pulse the block captures the word and a quarter-period length given in system clock cycles. The bit period is always four quarters. With a 100 MHz system clock and a quarter length of 100 cycles, the bit rate is 250 kHz. The block sets a busy flag for the length of the frame and gives a one-cycle done pulse when the frame ends. The frame has one idle state, `ST_IDLE`, and four quarter states that repeat once for each bit:

- `ST_LEAD`: the payload bit is on the data line and the clock is low.
- `ST_RISE`: the clock goes high and the payload bit is held.
- `ST_LATCH`: the latch flag is on the data line and the clock stays high.
- `ST_FALL`: the clock goes low and the latch flag is held.

The transitions are:

- IDLE→LEAD when a start is accepted.
- LEAD→RISE, RISE→LATCH and LATCH→FALL, each on the quarter tick.
- FALL→LEAD on the quarter tick when more bits remain.
- FALL→IDLE on the quarter tick after the final bit.

Top module: `qpt_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `sclk` is 0, `sdata` is 1, `busy` is 0 and `done` is 0.
- R2: A start pulse seen on a clock edge while idle is accepted at that edge. From that edge, `busy` is 1 for exactly 68·Q cycles (17 bits × 4 quarters), where Q is the captured quarter length.
- R3: Each frame produces exactly 17 rising edges on `sclk`.
- R4: The bit period is 4·Q cycles. During quarters 0 and 1 of bit b, `sdata` carries the payload bit, sent most significant bit first, so bit b is `word[16-b]`.
- R5: `sclk` is 1 during quarters 1 and 2 of each bit period and 0 during quarters 0 and 3. It rises Q cycles after the start of the bit period and falls 3·Q cycles after it.
- R6: During quarters 2 and 3 of each bit, `sdata` carries the latch flag. The flag is 1 for bits 0 to 15 and 0 for bit 16, the final bit.
- R7: `done` is 1 for exactly one cycle, in the same cycle that `busy` first reads 0 after a frame.
- R8: A start pulse that arrives while `busy` is 1 is ignored. The running frame continues unchanged with its original word.
- R9: The quarter length is captured when the start is accepted. A value of 0 is treated as 1. Changes to `qlen` during a frame have no effect on that frame.
- R10: `sdata` never changes in a cycle where `sclk` rises or falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame (taken only while idle) |
| word | input | 17 | Payload word, captured on an accepted start |
| qlen | input | 16 | Quarter-period length in clock cycles, captured on an accepted start |
| sdata | output | 1 | Serial data line |
| sclk | output | 1 | Serial clock line |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The assertions assume that reset is held for at least one edge before any start. They also assume the captured quarter length is at least one cycle. The block enforces this by clamping 0 to 1, so no input pattern can break it. The stimulus drives `start`, `word` and `qlen` only at falling edges. It includes a zero quarter length, and it deliberately pulses start and changes `qlen` in the middle of a frame, so that the properties are checked against inputs that are legal but hostile.

// File: rtl/qpt_pkg.sv
package qpt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_RISE,
        ST_LATCH,
        ST_FALL
    } qpt_state_e;
endpackage

// File: rtl/qpt_qtimer.sv
module qpt_qtimer #(
    parameter int QW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [QW-1:0] qlen_in,
    input  logic          run,
    output logic          tick
);
    logic [QW-1:0] ql;
    logic [QW-1:0] cnt;

    assign tick = run && (cnt == ql - QW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ql  <= QW'(1);
            cnt <= '0;
        end else if (load) begin
            ql  <= (qlen_in == '0) ? QW'(1) : qlen_in;
            cnt <= '0;
        end else if (run) begin
            cnt <= tick ? '0 : cnt + QW'(1);
        end else begin
            cnt <= '0;
        end
    end

    // R9
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt < ql));

    // R9
    ql_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        ql != '0);
endmodule

// File: rtl/qpt_shift.sv
module qpt_shift #(
    parameter int N = 17
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [N-1:0] word,
    input  logic         shift,
    output logic         head_nxt,
    output logic         last_nxt,
    output logic         is_last
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]  sreg, sreg_d;
    logic [CW-1:0] bcnt, bcnt_d;

    always_comb begin
        sreg_d = sreg;
        bcnt_d = bcnt;
        if (load) begin
            sreg_d = word;
            bcnt_d = '0;
        end else if (shift) begin
            sreg_d = {sreg[N-2:0], 1'b0};
            bcnt_d = bcnt + CW'(1);
        end
    end

    assign head_nxt = sreg_d[N-1];
    assign last_nxt = (bcnt_d == CW'(N - 1));
    assign is_last  = (bcnt == CW'(N - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
            bcnt <= '0;
        end else begin
            sreg <= sreg_d;
            bcnt <= bcnt_d;
        end
    end

    // R3
    no_shift_past_end_chk: assert property (@(posedge clk) disable iff (rst)
        (shift && !load) |-> !is_last);
endmodule

// File: rtl/qpt_tx.sv
module qpt_tx
    import qpt_pkg::*;
#(
    parameter int FRAME_BITS = 17,
    parameter int QW         = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] word,
    input  logic [QW-1:0]         qlen,
    output logic                  sdata,
    output logic                  sclk,
    output logic                  busy,
    output logic                  done
);
    qpt_state_e state, nstate;
    logic       accept;
    logic       tick;
    logic       head_nxt, last_nxt, is_last;
    logic       shift_en;
    logic       frame_end;

    assign accept    = start && (state == ST_IDLE);
    assign frame_end = (state == ST_FALL) && tick && is_last;
    assign shift_en  = (state == ST_FALL) && tick && !is_last;

    qpt_qtimer #(.QW(QW)) u_qtimer (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .qlen_in (qlen),
        .run     (state != ST_IDLE),
        .tick    (tick)
    );

    qpt_shift #(.N(FRAME_BITS)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .word     (word),
        .shift    (shift_en),
        .head_nxt (head_nxt),
        .last_nxt (last_nxt),
        .is_last  (is_last)
    );

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:  if (accept) nstate = ST_LEAD;
            ST_LEAD:  if (tick)   nstate = ST_RISE;
            ST_RISE:  if (tick)   nstate = ST_LATCH;
            ST_LATCH: if (tick)   nstate = ST_FALL;
            ST_FALL:  if (tick)   nstate = is_last ? ST_IDLE : ST_LEAD;
            default:              nstate = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nstate;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sdata <= 1'b1;
            sclk  <= 1'b0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= frame_end;
            busy <= (nstate != ST_IDLE);
            sclk <= (nstate == ST_RISE) || (nstate == ST_LATCH);
            unique case (nstate)
                ST_LEAD, ST_RISE:  sdata <= head_nxt;
                ST_LATCH, ST_FALL: sdata <= !last_nxt;
                default:           sdata <= 1'b1;
            endcase
        end
    end

    // R10
    data_stable_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> $stable(sdata));

    // R10
    data_stable_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk) |-> $stable(sdata));

    // R1
    idle_levels_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!sclk && sdata));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    done_with_busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $fell(busy));

    // R5
    clk_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> busy);
endmodule

// File: tb/qpt_tx_bench.sv
module qpt_tx_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [16:0] word_i = '0;
    logic [15:0] qlen_i = 16'd1;
    logic        sdata, sclk, busy, done;

    int nchk  = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    qpt_tx u_qpt_tx (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .word  (word_i),
        .qlen  (qlen_i),
        .sdata (sdata),
        .sclk  (sclk),
        .busy  (busy),
        .done  (done)
    );

    localparam int NV = 6;
    localparam logic [16:0] VW [NV] = '{17'h1FFFF, 17'h00000, 17'h15555,
                                        17'h0AAAA, 17'h10001, 17'h00F0F};
    localparam int          VQ [NV] = '{1, 2, 3, 1, 5, 0};

    task automatic chk(string tag, logic act, logic exp, string what);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic chk_idle(string tag);
        chk(tag, sclk, 1'b0, "sclk idle");
        chk(tag, sdata, 1'b1, "sdata idle");
        chk(tag, busy, 1'b0, "busy idle");
        chk(tag, done, 1'b0, "done idle");
    endtask

    task automatic run_frame(logic [16:0] w, int q, bit inject);
        int qe, per, total, rises, b, qu;
        logic prev, ec, ed;
        string tg;
        qe = (q == 0) ? 1 : q;
        per = 4 * qe;
        total = 17 * per;
        rises = 0;
        prev = 1'b0;
        @(negedge clk);
        start = 1'b1; word_i = w; qlen_i = 16'(q);
        for (int t = 0; t <= total; t++) begin
            @(negedge clk);
            if (t == 0) start = 1'b0;
            if (inject && t == 5) begin
                start = 1'b1; word_i = ~w; qlen_i = 16'(q + 3);
            end
            if (inject && t == 6) start = 1'b0;
            if (sclk && !prev) rises++;
            prev = sclk;
            if (t < total) begin
                b  = t / per;
                qu = (t % per) / qe;
                ec = (qu == 1 || qu == 2);
                ed = (qu < 2) ? w[16-b] : (b != 16);
                tg = inject ? "R8" : ((q == 0) ? "R9" : "R4");
                chk("R5", sclk, ec, "sclk quarter");
                chk((qu < 2) ? tg : "R6", sdata, ed, "sdata quarter");
                chk("R2", busy, 1'b1, "busy in frame");
                chk("R7", done, 1'b0, "done early");
            end else begin
                chk("R2", busy, 1'b0, "busy after frame");
                chk("R7", done, 1'b1, "done at end");
                chk("R1", sclk, 1'b0, "sclk rest");
                chk("R1", sdata, 1'b1, "sdata rest");
                nchk++;
                if (rises != 17) begin
                    nfail++;
                    $display("FAIL R3 clock pulses actual=%0d expected=17", rises);
                end
            end
        end
        @(negedge clk);
        chk("R7", done, 1'b0, "done single cycle");
        qlen_i = 16'(q);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_idle("R1");
        rst = 1'b0;
        @(negedge clk);
        chk_idle("R1");
        for (int i = 0; i < NV; i++) run_frame(VW[i], VQ[i], 1'b0);
        // R8 and R9: start pulse and quarter-length change mid-frame
        run_frame(17'h1A5C3, 2, 1'b1);
        run_frame(17'h0F00F, 1, 1'b1);
        // reset in mid-frame returns to idle (R1)
        @(negedge clk);
        start = 1'b1; word_i = 17'h00000; qlen_i = 16'd3;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk_idle("R1");
        run_frame(17'h12345, 1, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule